// File: doc/BRIEF.md
# Dual-Port Message Acknowledge Tracker

This block follows one outgoing message on an embedded control channel that runs over two redundant link ports, A and B, and reports when the far end has confirmed delivery. Software writes a control word that enables one port, the other, or both, and that picks for each port which of two incoming status lines counts as that port's acknowledge. Setting the start bit in the same word marks a new message as outstanding. The block then watches the selected acknowledge of each enabled port and raises a released flag once the enabled set of ports has confirmed the message. In single-port modes one confirmation is enough. In dual-port mode both are needed, and they may arrive in any order on different cycles.

With both enables clear the channel is switched off. Every flag is held low, and start requests and incoming status lines have no effect. Each port also keeps a receive-buffer-full flag that sets when that port reports an incoming message. Software clears the flag by writing one to it. On a disabled port the flag is held at zero.

Top module: `msg_ack_tracker`

## Requirements
- R1: After reset the status word, the control readback and the flag outputs released, send_busy, bfull_a and bfull_b all read 0.
- R2: With control bits [1:0] = 01 (port A only), released sets on the clock edge that samples port A's selected acknowledge while a message is outstanding. Port B status lines are ignored and bfull_b stays 0.
- R3: With control bits [1:0] = 10 (port B only), released sets on port B's selected acknowledge. Port A status lines are ignored and bfull_a stays 0.
- R4: With control bits [1:0] = 11, released sets only once both ports have acknowledged the current message, in either order. An acknowledge from one port alone leaves released at 0.
- R5: With control bits [1:0] = 00, released, send_busy, bfull_a and bfull_b are all 0. A start request is ignored, and status lines and rx_done inputs have no effect.
- R6: Control bit 2 (port A) and bit 3 (port B) select that port's acknowledge: 0 takes status line [0] and 1 takes status line [1]. The other line is ignored.
- R7: Status word at address 1: bit 0 released, bit 1 send busy, bit 2 port A buffer full, bit 3 port B buffer full. Bits 0 and 1 are read-only, so writes to them have no effect.
- R8: Writing control with bit 4 (start) set and a nonzero enable pair sets send_busy, clears released and discards earlier acknowledges. send_busy clears on the edge where released sets.
- R9: A control write that changes the enable pair without start clears send_busy, released and every recorded acknowledge on that edge.
- R10: On an enabled port, an rx_done pulse sets that port's buffer-full flag, and writing 1 to its status bit clears it. When the pulse and the clear arrive together, the pulse wins.
- R11: Acknowledges that arrive while no message is outstanding (send_busy = 0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 status |
| wr_data | input | 5 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | 5 | Combinational read data |
| stat_a | input | 2 | Port A received status lines |
| stat_b | input | 2 | Port B received status lines |
| rx_done_a | input | 1 | Port A incoming message strobe |
| rx_done_b | input | 1 | Port B incoming message strobe |
| released | output | 1 | Message confirmed, buffer released |
| send_busy | output | 1 | Message outstanding |
| bfull_a | output | 1 | Port A receive buffer full |
| bfull_b | output | 1 | Port B receive buffer full |

## Verification
The bench sweeps every enable pair, every select pair and every combination of status lines on both ports. In each case port A pulses first and port B second, and the bench works out arithmetically whether released must be set after each pulse. A design that gated with the wrong select line, let a disabled port count, or released on one acknowledge in dual mode would show released high where the bench expects it low, or the reverse. Directed cases cover B-before-A ordering, acknowledges with no message outstanding, a restart after release, and an enable change that must discard a recorded acknowledge. A design that kept stale acknowledges would release on the second port alone. The disabled mode is also checked, since it must ignore a start request and rx_done.

// File: rtl/mat_pkg.sv
package mat_pkg;

  localparam int NPORTS = 2;
  localparam int REG_W  = 5;

  // control word bit positions
  localparam int C_EN_LO  = 0;   // enables occupy [C_EN_LO +: NPORTS]
  localparam int C_SEL_LO = 2;   // selects occupy [C_SEL_LO +: NPORTS]
  localparam int C_START  = 4;

  // status word bit positions
  localparam int S_REL    = 0;
  localparam int S_SEND   = 1;
  localparam int S_BF_LO  = 2;   // buffer-full flags occupy [S_BF_LO +: NPORTS]

  typedef enum logic [NPORTS-1:0] {
    MODE_OFF = 2'b00,
    MODE_A   = 2'b01,
    MODE_B   = 2'b10,
    MODE_AB  = 2'b11
  } mode_e;

  // acknowledge of one port: the status line chosen by its select bit
  function automatic logic pick_ack(input logic [1:0] stat, input logic sel);
    return sel ? stat[1] : stat[0];
  endfunction

  // release condition: every enabled port has acknowledged
  function automatic logic release_met(input logic [NPORTS-1:0] en,
                                       input logic [NPORTS-1:0] have);
    return (en != '0) && ((have & en) == en);
  endfunction

endpackage

// File: rtl/mat_ctrl_regs.sv
module mat_ctrl_regs
  import mat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  output logic [NPORTS-1:0]   en_q,
  output logic [NPORTS-1:0]   en_next,
  output logic [NPORTS-1:0]   sel_q,
  output logic                start,
  output logic                cfg_change,
  output logic [NPORTS-1:0]   clr_bfull
);

  logic                wr_ctrl;
  logic                wr_stat;
  logic [NPORTS-1:0]   sel_next;

  assign wr_ctrl = wr_en && (wr_addr == 1'b0);
  assign wr_stat = wr_en && (wr_addr == 1'b1);

  assign en_next  = wr_ctrl ? wr_data[C_EN_LO  +: NPORTS] : en_q;
  assign sel_next = wr_ctrl ? wr_data[C_SEL_LO +: NPORTS] : sel_q;

  assign start      = wr_ctrl && wr_data[C_START] && (en_next != '0);
  assign cfg_change = wr_ctrl && (en_next != en_q);
  assign clr_bfull  = wr_stat ? wr_data[S_BF_LO +: NPORTS] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      en_q  <= en_next;
      sel_q <= sel_next;
    end
  end

endmodule

// File: rtl/mat_port_ack.sv
module mat_port_ack
  import mat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_now,
  input  logic        en_nxt,
  input  logic        sel,
  input  logic [1:0]  stat,
  input  logic        send,
  input  logic        clear_pend,
  input  logic        rx_done,
  input  logic        clr_bfull,
  output logic        ack_g,
  output logic        seen,
  output logic        bfull
);

  assign ack_g = en_now && send && pick_ack(stat, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      bfull <= 1'b0;
    end else begin
      if (!en_nxt || clear_pend) seen <= 1'b0;
      else if (ack_g)            seen <= 1'b1;

      if (!en_nxt)        bfull <= 1'b0;
      else if (rx_done)   bfull <= 1'b1;
      else if (clr_bfull) bfull <= 1'b0;
    end
  end

endmodule

// File: rtl/mat_release.sv
module mat_release
  import mat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORTS-1:0]   en_q,
  input  logic [NPORTS-1:0]   en_next,
  input  logic [NPORTS-1:0]   seen,
  input  logic [NPORTS-1:0]   ack_g,
  input  logic                start,
  input  logic                cfg_change,
  output logic                released,
  output logic                send,
  output logic                rel_event
);

  logic clear_pend;

  assign clear_pend = start || cfg_change;
  assign rel_event  = send && release_met(en_q, seen | ack_g) && !clear_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released <= 1'b0;
      send     <= 1'b0;
    end else begin
      if (clear_pend || (en_next == '0)) released <= 1'b0;
      else if (rel_event)                released <= 1'b1;

      if (start)                                  send <= 1'b1;
      else if (cfg_change || (en_next == '0))     send <= 1'b0;
      else if (rel_event)                         send <= 1'b0;
    end
  end

endmodule

// File: rtl/msg_ack_tracker.sv
module msg_ack_tracker
  import mat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [1:0]        stat_a,
  input  logic [1:0]        stat_b,
  input  logic              rx_done_a,
  input  logic              rx_done_b,
  output logic              released,
  output logic              send_busy,
  output logic              bfull_a,
  output logic              bfull_b
);

  logic [NPORTS-1:0]        en_q;
  logic [NPORTS-1:0]        en_next;
  logic [NPORTS-1:0]        sel_q;
  logic                     start;
  logic                     cfg_change;
  logic [NPORTS-1:0]        clr_bfull;
  logic [NPORTS-1:0]        seen;
  logic [NPORTS-1:0]        ack_g;
  logic [NPORTS-1:0]        bfull;
  logic [NPORTS-1:0][1:0]   stat_all;
  logic [NPORTS-1:0]        rx_all;
  logic                     rel_event;

  assign stat_all = {stat_b, stat_a};
  assign rx_all   = {rx_done_b, rx_done_a};

  mat_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .en_q       (en_q),
    .en_next    (en_next),
    .sel_q      (sel_q),
    .start      (start),
    .cfg_change (cfg_change),
    .clr_bfull  (clr_bfull)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    mat_port_ack u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_now     (en_q[p]),
      .en_nxt     (en_next[p]),
      .sel        (sel_q[p]),
      .stat       (stat_all[p]),
      .send       (send_busy),
      .clear_pend (start || cfg_change),
      .rx_done    (rx_all[p]),
      .clr_bfull  (clr_bfull[p]),
      .ack_g      (ack_g[p]),
      .seen       (seen[p]),
      .bfull      (bfull[p])
    );
  end

  mat_release u_rel (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .en_next    (en_next),
    .seen       (seen),
    .ack_g      (ack_g),
    .start      (start),
    .cfg_change (cfg_change),
    .released   (released),
    .send       (send_busy),
    .rel_event  (rel_event)
  );

  assign bfull_a = bfull[0];
  assign bfull_b = bfull[1];

  always_comb begin
    rd_data = '0;
    if (rd_addr == 1'b0) begin
      rd_data[C_EN_LO  +: NPORTS] = en_q;
      rd_data[C_SEL_LO +: NPORTS] = sel_q;
    end else begin
      rd_data[S_REL]              = released;
      rd_data[S_SEND]             = send_busy;
      rd_data[S_BF_LO +: NPORTS]  = bfull;
    end
  end

endmodule

// File: rtl/mat_checker.sv
module mat_checker
  import mat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] en_q,
  input logic [NPORTS-1:0] sel_q,
  input logic              start,
  input logic              cfg_change,
  input logic [NPORTS-1:0] seen,
  input logic [1:0]        stat_a,
  input logic              rel_event,
  input logic              released,
  input logic              send_busy,
  input logic              bfull_a,
  input logic              bfull_b
);

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == MODE_OFF) |-> (!released && !send_busy && !bfull_a && !bfull_b));

  assert_a_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == MODE_A) |-> (!seen[1] && !bfull_b));

  assert_b_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == MODE_B) |-> (!seen[0] && !bfull_a));

  assert_start_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (send_busy && !released && (seen == '0)));

  assert_release_drops_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_event |=> (released && !send_busy));

  assert_change_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_change && !start) |=> (!send_busy && !released && (seen == '0)));

  assert_idle_no_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_busy && !start && !cfg_change) |=> $stable(seen) || (seen == '0));

  assert_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q == MODE_A) && send_busy && !start && !cfg_change &&
     (sel_q[0] ? stat_a[1] : stat_a[0])) |=> seen[0]);

endmodule

bind msg_ack_tracker mat_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_q       (en_q),
  .sel_q      (sel_q),
  .start      (start),
  .cfg_change (cfg_change),
  .seen       (seen),
  .stat_a     (stat_a),
  .rel_event  (rel_event),
  .released   (released),
  .send_busy  (send_busy),
  .bfull_a    (bfull_a),
  .bfull_b    (bfull_b)
);

// File: tb/tb_msg_ack_tracker.sv
module tb_msg_ack_tracker;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [4:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [4:0] rd_data;
  logic [1:0] stat_a = '0;
  logic [1:0] stat_b = '0;
  logic       rx_done_a = 1'b0;
  logic       rx_done_b = 1'b0;
  logic       released, send_busy, bfull_a, bfull_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  msg_ack_tracker dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stat_a(stat_a), .stat_b(stat_b), .rx_done_a(rx_done_a),
    .rx_done_b(rx_done_b), .released(released), .send_busy(send_busy),
    .bfull_a(bfull_a), .bfull_b(bfull_b)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [4:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [1:0] sa, input logic [1:0] sb);
    @(negedge clk);
    stat_a = sa; stat_b = sb;
    @(negedge clk);
    stat_a = '0; stat_b = '0;
  endtask

  task automatic rd_status(output logic [4:0] v);
    rd_addr = 1'b1; #1; v = rd_data;
  endtask

  function automatic logic [4:0] status_word(input logic rel, input logic snd,
                                             input logic bfa, input logic bfb);
    return {1'b0, bfb, bfa, snd, rel};
  endfunction

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [4:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_status(v);
    check("R1 status", v, '0);
    rd_addr = 1'b0; #1;
    check("R1 control", rd_data, '0);
    check("R1 flags", {1'b0, released, send_busy, bfull_a, bfull_b}, '0);

    // R11 ack with no outstanding message
    wr(1'b0, 5'b00001);
    pulse(2'b11, 2'b11);
    rd_status(v);
    check("R11 idle ack", v, '0);

    // sweep: R2 R3 R4 R5 R6
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 16; p++) begin
          logic ea, eb, aa, ab, exp_mid, exp_end;
          logic [1:0] pa, pb;
          pa = p[1:0]; pb = p[3:2];
          ea = m[0]; eb = m[1];
          aa = ea & pa[s[0]];
          ab = eb & pb[s[1]];
          wr(1'b0, {1'b1, s[1:0], m[1:0]});
          pulse(pa, 2'b00);
          exp_mid = (m == 1) ? aa : 1'b0;
          rd_status(v);
          check("R2 R4 R6 after port A", v,
                status_word(exp_mid, (m != 0) && !exp_mid, 1'b0, 1'b0));
          pulse(2'b00, pb);
          case (m)
            1: exp_end = aa;
            2: exp_end = ab;
            3: exp_end = aa & ab;
            default: exp_end = 1'b0;
          endcase
          rd_status(v);
          check("R3 R4 R5 R6 after port B", v,
                status_word(exp_end, (m != 0) && !exp_end, 1'b0, 1'b0));
        end

    // R4 reverse order B then A
    wr(1'b0, 5'b10011);
    pulse(2'b00, 2'b01);
    rd_status(v);
    check("R4 B only so far", v, status_word(1'b0, 1'b1, 1'b0, 1'b0));
    pulse(2'b01, 2'b00);
    rd_status(v);
    check("R4 B then A", v, status_word(1'b1, 1'b0, 1'b0, 1'b0));

    // R7 read-only bits ignore writes
    wr(1'b1, 5'b00011);
    rd_status(v);
    check("R7 ro bits", v, status_word(1'b1, 1'b0, 1'b0, 1'b0));

    // R8 restart clears released
    wr(1'b0, 5'b10011);
    rd_status(v);
    check("R8 restart", v, status_word(1'b0, 1'b1, 1'b0, 1'b0));

    // R9 enable change discards recorded ack
    pulse(2'b01, 2'b00);
    wr(1'b0, 5'b00001);
    rd_status(v);
    check("R9 change clears send", v, '0);
    wr(1'b0, 5'b10011);
    pulse(2'b00, 2'b01);
    rd_status(v);
    check("R9 stale ack gone", v, status_word(1'b0, 1'b1, 1'b0, 1'b0));

    // R10 buffer-full flags
    @(negedge clk); rx_done_a = 1'b1; rx_done_b = 1'b1;
    @(negedge clk); rx_done_a = 1'b0; rx_done_b = 1'b0;
    check("R10 set both", {3'b000, bfull_b, bfull_a}, 5'b00011);
    wr(1'b1, 5'b00100);
    check("R10 clear A", {3'b000, bfull_b, bfull_a}, 5'b00010);
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b1; wr_data = 5'b01000; rx_done_b = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; rx_done_b = 1'b0;
    check("R10 set wins", {3'b000, bfull_b, bfull_a}, 5'b00010);
    wr(1'b0, 5'b00001);
    check("R10 disabled B held", {3'b000, bfull_b, bfull_a}, 5'b00000);
    @(negedge clk); rx_done_b = 1'b1;
    @(negedge clk); rx_done_b = 1'b0;
    check("R10 R2 B rx ignored", {3'b000, bfull_b, bfull_a}, 5'b00000);

    // R5 off mode ignores start and rx
    wr(1'b0, 5'b10000);
    @(negedge clk); rx_done_a = 1'b1;
    @(negedge clk); rx_done_a = 1'b0;
    rd_status(v);
    check("R5 off mode", v, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule